// File: doc/BRIEF.md
# Keyed LFSR Stream Scrambler

This block encrypts or decrypts a bit-serial data stream. Every valid data bit is XORed with one bit of a keystream, and the keystream comes from an 11-bit maximal-length linear feedback shift register with the polynomial x^11 + x^9 + 1 in Fibonacci form. An 8-bit key picks the generator's starting point, so there are 255 distinct starting points in the 2047-bit cycle. A key of zero turns the XOR off, and data then passes through unchanged.

The same block sits at both ends of a link. XOR is its own inverse, so the receiver recovers the data when it holds the same key and resynchronises at the same bit as the transmitter. Software may write a key at any time. The key is stored first and only becomes active on the next resynchronisation pulse, which also reloads the generator from the stored key. The surrounding framing logic raises that pulse at frame or field boundaries. The output is registered and follows the input by one cycle.

Top module: `scramble_core`

## Requirements
- R1: After reset, dout_valid and dout are 0, and the active key and the stored key are both 0, so data passes through until a nonzero key is written and a resync occurs.
- R2: dout_valid equals din_valid of the previous cycle. dout carries that cycle's result when dout_valid is 1 and is 0 when dout_valid is 0.
- R3: While the active key is 0x00, each valid bit leaves unchanged: dout equals din.
- R4: While the active key is nonzero, the keystream bit is bit 10 (the MSB) of the 11-bit generator state s, and dout = din XOR s[10]. After each valid bit the state becomes {s[9:0], s[10] XOR s[8]}.
- R5: A resync pulse loads the generator with the seed {3'b001, K}, where K is the stored key as it was before any write in the same cycle. It also makes K the active key.
- R6: A key write changes only the stored key. The active key and the keystream keep their values until the next resync.
- R7: The generator advances only on cycles with din_valid = 1. Idle cycles between valid bits do not change the keystream applied to the later bits.
- R8: When resync and din_valid are both high in one cycle, that bit is processed with the new active key and with bit 10 of the new seed, and the generator then advances once from the seed.
- R9: Passing a stream through the block twice with the same key, with a resync before each pass, returns the original data.
- R10: The generator state is never all zeros, and with a nonzero key the keystream repeats with a period of 2047 valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr | input | 1 | Strobe that writes key_wdata into the stored key |
| key_wdata | input | 8 | Key value to store |
| resync | input | 1 | Reloads the seed and activates the stored key |
| din_valid | input | 1 | Qualifies din for this cycle |
| din | input | 1 | Serial input bit |
| dout_valid | output | 1 | Qualifies dout, one cycle after din_valid |
| dout | output | 1 | Scrambled or passed-through bit |

## Verification
The block is driven with several input patterns. A stream of all zeros exposes the raw keystream. Alternating and mixed bit patterns show that each output bit is the XOR of the input bit and the keystream, and not the keystream alone. Streams with idle gaps separate "advance per valid bit" from "advance per clock". A key write without a resync, and a key write in the same cycle as a resync, show when a new key takes effect. A resync in the same cycle as a valid bit pins down which seed bit that data bit uses. A round trip through the block with the same key confirms that decryption works, and a run of 2047 + 11 zero bits confirms the period.

// File: rtl/scram_pkg.sv
`timescale 1ns/1ps
package scram_pkg;
  parameter int LFSR_W = 11;
  parameter int KEY_W  = 8;
  parameter int TAP_HI = LFSR_W - 1;   // x^11 term: output / feedback
  parameter int TAP_LO = 8;            // x^9 term
  localparam int PAD_W = LFSR_W - KEY_W;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [KEY_W-1:0]  key_t;

  // One Fibonacci step of x^11 + x^9 + 1
  function automatic lfsr_t lfsr_advance(input lfsr_t s);
    return {s[LFSR_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
  endfunction

  // Seed: pad of 0..01 above the key, never zero
  function automatic lfsr_t seed_from_key(input key_t k);
    logic [PAD_W-1:0] pad;
    pad = {{(PAD_W-1){1'b0}}, 1'b1};
    return {pad, k};
  endfunction

  function automatic logic key_is_off(input key_t k);
    return (k == '0);
  endfunction
endpackage

// File: rtl/scram_key_hold.sv
`timescale 1ns/1ps
module scram_key_hold
  import scram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic key_wr,
  input  key_t key_wdata,
  input  logic resync,
  output key_t key_q,
  output key_t active_key_q,
  output logic eff_bypass
);
  key_t eff_key;

  // A resync this cycle already uses the stored key
  assign eff_key    = resync ? key_q : active_key_q;
  assign eff_bypass = key_is_off(eff_key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q        <= '0;
      active_key_q <= '0;
    end else begin
      if (key_wr) key_q <= key_wdata;
      active_key_q <= eff_key;
    end
  end
endmodule

// File: rtl/scram_lfsr.sv
`timescale 1ns/1ps
module scram_lfsr
  import scram_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  resync,
  input  logic  step_en,
  input  key_t  seed_key,
  output lfsr_t state_q,
  output logic  key_bit
);
  lfsr_t base_state;

  assign base_state = resync ? seed_from_key(seed_key) : state_q;
  assign key_bit    = base_state[TAP_HI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= seed_from_key('0);
    else if (step_en) state_q <= lfsr_advance(base_state);
    else              state_q <= base_state;
  end
endmodule

// File: rtl/scram_xor_out.sv
`timescale 1ns/1ps
module scram_xor_out (
  input  logic clk,
  input  logic rst_n,
  input  logic din_valid,
  input  logic din,
  input  logic key_bit,
  input  logic bypass,
  output logic dout_valid,
  output logic dout
);
  logic mask;
  assign mask = key_bit & ~bypass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_valid <= 1'b0;
      dout       <= 1'b0;
    end else begin
      dout_valid <= din_valid;
      dout       <= din_valid ? (din ^ mask) : 1'b0;
    end
  end
endmodule

// File: rtl/scramble_core.sv
`timescale 1ns/1ps
module scramble_core
  import scram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_wdata,
  input  logic       resync,
  input  logic       din_valid,
  input  logic       din,
  output logic       dout_valid,
  output logic       dout
);
  // Named internal events, brought out for the checker
  key_t  key_q;
  key_t  active_key_q;
  logic  eff_bypass;
  lfsr_t state_q;
  logic  key_bit;

  scram_key_hold u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_wdata(key_wdata),
    .resync(resync), .key_q(key_q), .active_key_q(active_key_q),
    .eff_bypass(eff_bypass)
  );

  scram_lfsr u_gen (
    .clk(clk), .rst_n(rst_n), .resync(resync), .step_en(din_valid),
    .seed_key(key_q), .state_q(state_q), .key_bit(key_bit)
  );

  scram_xor_out u_out (
    .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din(din),
    .key_bit(key_bit), .bypass(eff_bypass),
    .dout_valid(dout_valid), .dout(dout)
  );
endmodule

// File: rtl/scram_chk.sv
`timescale 1ns/1ps
module scram_chk
  import scram_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  resync,
  input logic  din_valid,
  input logic  din,
  input logic  dout_valid,
  input logic  dout,
  input key_t  key_q,
  input key_t  active_key_q,
  input logic  eff_bypass,
  input lfsr_t state_q,
  input logic  key_bit
);
  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    din_valid |=> dout_valid); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !din_valid |=> (!dout_valid && !dout)); // R2
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && eff_bypass) |=> (dout == $past(din))); // R3
  AST_ENCRYPT: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && !eff_bypass) |=> (dout == ($past(din) ^ $past(key_bit)))); // R4
  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && !din_valid) |=> (state_q == seed_from_key($past(key_q)))); // R5
  AST_ACTIVE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !resync |=> $stable(active_key_q)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!resync && !din_valid) |=> $stable(state_q)); // R7

  always @(posedge clk) begin
    if (rst_n) begin
      AST_STATE_NONZERO: assert (state_q != '0); // R10
    end
  end
endmodule

bind scramble_core scram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .resync(resync), .din_valid(din_valid),
  .din(din), .dout_valid(dout_valid), .dout(dout), .key_q(key_q),
  .active_key_q(active_key_q), .eff_bypass(eff_bypass),
  .state_q(state_q), .key_bit(key_bit)
);

// File: tb/test_scramble_core.sv
`timescale 1ns/1ps
module test_scramble_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_wr = 1'b0;
  logic [7:0] key_wdata = '0;
  logic resync = 1'b0;
  logic din_valid = 1'b0;
  logic din = 1'b0;
  logic dout_valid, dout;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Bench model, written from the requirements
  int m_state;   // 11-bit generator value
  int m_key;     // stored key
  int m_active;  // active key

  always #2.5 clk = ~clk;  // 200 MHz

  scramble_core i_scramble_core (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_wdata(key_wdata),
    .resync(resync), .din_valid(din_valid), .din(din),
    .dout_valid(dout_valid), .dout(dout)
  );

  function automatic int m_next(input int s);
    return ((s * 2) % 2048) + (((s / 1024) + (s / 256)) % 2);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, sample at the next negedge
  task automatic cyc(input bit v, input bit d, input bit rs, input bit wr,
                     input int kd, input string req, output bit obit);
    int eff, base, ebit;
    din_valid = v; din = d; resync = rs; key_wr = wr; key_wdata = kd[7:0];
    eff  = rs ? m_key : m_active;
    base = rs ? (256 + m_key) : m_state;
    ebit = v ? (d ^ ((eff != 0) ? ((base / 1024) % 2) : 0)) : 0;
    m_active = eff;
    m_state  = v ? m_next(base) : base;
    if (wr) m_key = kd;
    @(negedge clk);
    din_valid = 0; din = 0; resync = 0; key_wr = 0;
    check({req, " valid"}, dout_valid, v);
    check({req, " data"}, dout, ebit);
    obit = dout;
  endtask

  task automatic t_reset();
    check("R1 reset valid", dout_valid, 0);
    check("R1 reset data", dout, 0);
  endtask

  task automatic t_passthrough();
    bit o;
    for (int i = 0; i < 12; i++) begin
      cyc(1, i[0] ^ i[2], 0, 0, 0, "R1/R3 pass", o);
      check("R3 equal", o, i[0] ^ i[2]);
    end
  endtask

  task automatic t_encrypt(input int key, input int pat);
    bit o;
    cyc(0, 0, 0, 1, key, "R5 write", o);
    cyc(0, 0, 1, 0, 0, "R5 resync", o);
    for (int i = 0; i < 40; i++)
      cyc(1, (pat >> (i % 16)) & 1, 0, 0, 0, "R4 encrypt", o);
  endtask

  task automatic t_key_deferred();
    bit o;
    cyc(0, 0, 0, 1, 8'h3C, "R6 write", o);
    for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0, 0, "R6 old key stream", o);
    cyc(0, 0, 1, 1, 8'h00, "R6 write with resync", o);
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, 0, "R6 key 3C active", o);
    cyc(0, 0, 1, 0, 0, "R6 resync to zero", o);
    for (int i = 0; i < 6; i++) begin
      cyc(1, 1, 0, 0, 0, "R6 zero active", o);
      check("R6/R3 pass after zero key", o, 1);
    end
  endtask

  task automatic t_gaps();
    bit o;
    cyc(0, 0, 0, 1, 8'hA7, "R7 write", o);
    cyc(0, 0, 1, 0, 0, "R7 resync", o);
    for (int i = 0; i < 24; i++) begin
      cyc(1, i[1], 0, 0, 0, "R7 gapped data", o);
      for (int g = 0; g < (i % 3); g++) cyc(0, 0, 0, 0, 0, "R7 idle", o);
    end
  endtask

  task automatic t_resync_same();
    bit o;
    cyc(0, 0, 0, 1, 8'h81, "R8 write", o);
    // seed 001_1000_0001: MSB 0, so dout equals din on this bit
    cyc(1, 1, 1, 0, 0, "R8 resync with data", o);
    check("R8 first bit seed MSB", o, 1);
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, "R8 after seed", o);
  endtask

  task automatic t_roundtrip();
    bit o;
    bit enc[48];
    cyc(0, 0, 0, 1, 8'h6D, "R9 write", o);
    cyc(0, 0, 1, 0, 0, "R9 resync", o);
    for (int i = 0; i < 48; i++) begin
      cyc(1, (i * 7 % 5) > 2, 0, 0, 0, "R9 encrypt", o);
      enc[i] = o;
    end
    cyc(0, 0, 1, 0, 0, "R9 resync", o);
    for (int i = 0; i < 48; i++) begin
      cyc(1, enc[i], 0, 0, 0, "R9 decrypt", o);
      check("R9 round trip", o, ((i * 7 % 5) > 2) ? 1 : 0);
    end
  endtask

  task automatic t_period();
    bit o;
    bit head[11];
    cyc(0, 0, 0, 1, 8'h5A, "R10 write", o);
    cyc(0, 0, 1, 0, 0, "R10 resync", o);
    for (int i = 0; i < 2047 + 11; i++) begin
      cyc(1, 0, 0, 0, 0, "R10 stream", o);
      if (i < 11) head[i] = o;
      else if (i >= 2047) check("R10 period 2047", o, head[i - 2047]);
    end
  endtask

  initial begin
    m_state = 256; m_key = 0; m_active = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_encrypt(8'h01, 16'h0000);
    t_encrypt(8'hFF, 16'hAAAA);
    t_encrypt(8'h93, 16'hC35A);
    t_key_deferred();
    t_gaps();
    t_resync_same();
    t_roundtrip();
    t_period();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule